// File: doc/BRIEF.md
# Domain and Permission Access Checker

This block decides, for each memory access, whether the access may proceed. Its inputs are attributes from an already translated descriptor: a domain number and a 2-bit permission code. It also takes the kind of access (read or write), the privilege level of the requester, a 32-bit domain control word, and two override bits. The overrides give extra meaning to the all-zero permission code. The block answers either with a grant or with exactly one fault: a domain fault or a permission fault.

The check has two stages. First, the 2-bit mode field that belongs to the requested domain is taken from the control word. This mode either blocks the access outright, sends it on to the permission check, or lets it through with no check. Second, when the permission check applies, the permission code is matched against the access kind and the privilege level. For the zero code, the two override bits also take part.

The verdict is held in a small state register with four states:
- `ST_IDLE`: no response.
- `ST_GRANT`: the access is allowed.
- `ST_DOM_FLT`: a domain fault.
- `ST_PERM_FLT`: a permission fault.

On every clock the register takes one of two transitions. A "take" transition loads the verdict of the request present on that edge. An "idle" transition returns to `ST_IDLE` when no request is present. The response therefore appears exactly one cycle after the request.

Top module: `acc_guard`

## Requirements
- R1: The mode for domain d is control-word bits [2d+1:2d]. Mode encodings: 00 block, 01 client, 10 reserved, 11 owner.
- R2: With mode 00, every access produces a domain fault and no grant.
- R3: Mode 10 behaves exactly like mode 00: a domain fault for every access.
- R4: With mode 11, every access is granted and no permission fault is ever raised.
- R5: Client mode with permission code 01 grants supervisor reads and writes, and faults every user access with a permission fault.
- R6: Client mode with permission code 10 grants all supervisor accesses and user reads, and faults user writes.
- R7: Client mode with permission code 11 grants every access.
- R8: Client mode with permission code 00 depends on the overrides {S,R}. With 00, every access faults. With S=1, R=0, only supervisor reads are granted. With S=0, R=1, reads are granted at both levels and writes fault.
- R9: Client mode with permission code 00 and S=R=1 faults every access, the same as no access.
- R10: A response carries exactly one of grant, domain fault or permission fault. The domain fault wins whenever the mode blocks.
- R11: The response valid follows the request valid by exactly one clock cycle.
- R12: An active-low reset clears the response valid, the grant and both fault outputs at once.
- R13: When the response valid is low, the grant and both fault outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_domain | input | 4 | Domain number of the access |
| req_ap | input | 2 | Permission code from the descriptor |
| req_write | input | 1 | 1 = write, 0 = read |
| req_priv | input | 1 | 1 = supervisor, 0 = user |
| dacr | input | 32 | Domain control word, 2 bits per domain |
| ovr_s | input | 1 | Override S for permission code 00 |
| ovr_r | input | 1 | Override R for permission code 00 |
| rsp_valid | output | 1 | Response valid |
| rsp_allow | output | 1 | Access granted |
| rsp_dom_fault | output | 1 | Domain fault |
| rsp_perm_fault | output | 1 | Permission fault |

## Verification
The bench sweeps every combination of domain mode, permission code, override pair, access kind and privilege level. This separates the blocking modes from the owner bypass, and each permission row from the others.

A second pass makes one domain owner and blocks all the others, then moves the request across all sixteen domains. This shows that each domain reads its own 2-bit field and no neighbouring field.

Idle gaps between requests show that the response valid tracks the request valid with a one-cycle lag. A reset issued in the middle of a request shows that the outputs clear at once.

// File: rtl/acc_guard_pkg.sv
package acc_guard_pkg;

    localparam int MODE_W = 2;
    localparam int AP_W   = 2;

    typedef enum logic [MODE_W-1:0] {
        DM_BLOCK  = 2'b00,
        DM_CLIENT = 2'b01,
        DM_RSVD   = 2'b10,
        DM_OWNER  = 2'b11
    } dom_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_GRANT    = 2'd1,
        ST_DOM_FLT  = 2'd2,
        ST_PERM_FLT = 2'd3
    } verdict_st_e;

endpackage

// File: rtl/acc_guard_dom_sel.sv
module acc_guard_dom_sel
    import acc_guard_pkg::*;
#(
    parameter int NUM_DOMAINS = 16,
    localparam int DOM_W  = $clog2(NUM_DOMAINS),
    localparam int DACR_W = NUM_DOMAINS * MODE_W
) (
    input  logic [DACR_W-1:0] dacr_i,
    input  logic [DOM_W-1:0]  dom_i,
    output dom_mode_e         mode_o
);

    logic [MODE_W-1:0] field_a [NUM_DOMAINS];

    for (genvar g = 0; g < NUM_DOMAINS; g++) begin : g_field
        assign field_a[g] = dacr_i[g*MODE_W +: MODE_W];
    end

    assign mode_o = dom_mode_e'(field_a[dom_i]);

endmodule

// File: rtl/acc_guard_perm_eval.sv
module acc_guard_perm_eval
    import acc_guard_pkg::*;
(
    input  logic [AP_W-1:0] ap_i,
    input  logic            ovr_s_i,
    input  logic            ovr_r_i,
    input  logic            write_i,
    input  logic            priv_i,
    output logic            perm_ok_o
);

    always_comb begin
        perm_ok_o = 1'b0;
        unique case (ap_i)
            2'b00: begin
                unique case ({ovr_s_i, ovr_r_i})
                    2'b10:   perm_ok_o = priv_i && !write_i;
                    2'b01:   perm_ok_o = !write_i;
                    default: perm_ok_o = 1'b0;   // 00 denies, 11 is reserved
                endcase
            end
            2'b01:   perm_ok_o = priv_i;
            2'b10:   perm_ok_o = priv_i || !write_i;
            default: perm_ok_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/acc_guard_verdict.sv
module acc_guard_verdict
    import acc_guard_pkg::*;
(
    input  dom_mode_e   mode_i,
    input  logic        perm_ok_i,
    output verdict_st_e verdict_o
);

    // Domain stage first: a blocking mode never reaches the permission stage.
    always_comb begin
        verdict_o = ST_DOM_FLT;
        unique case (mode_i)
            DM_BLOCK, DM_RSVD: verdict_o = ST_DOM_FLT;
            DM_OWNER:          verdict_o = ST_GRANT;
            DM_CLIENT:         verdict_o = perm_ok_i ? ST_GRANT : ST_PERM_FLT;
            default:           verdict_o = ST_DOM_FLT;
        endcase
    end

endmodule

// File: rtl/acc_guard.sv
module acc_guard
    import acc_guard_pkg::*;
#(
    parameter int NUM_DOMAINS = 16,
    localparam int DOM_W  = $clog2(NUM_DOMAINS),
    localparam int DACR_W = NUM_DOMAINS * MODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [DOM_W-1:0]  req_domain,
    input  logic [AP_W-1:0]   req_ap,
    input  logic              req_write,
    input  logic              req_priv,
    input  logic [DACR_W-1:0] dacr,
    input  logic              ovr_s,
    input  logic              ovr_r,
    output logic              rsp_valid,
    output logic              rsp_allow,
    output logic              rsp_dom_fault,
    output logic              rsp_perm_fault
);

    dom_mode_e   cur_mode;
    logic        perm_ok;
    verdict_st_e verdict;
    verdict_st_e state_q, state_d;

    acc_guard_dom_sel #(.NUM_DOMAINS(NUM_DOMAINS)) u_dom_sel (
        .dacr_i (dacr),
        .dom_i  (req_domain),
        .mode_o (cur_mode)
    );

    acc_guard_perm_eval u_perm_eval (
        .ap_i      (req_ap),
        .ovr_s_i   (ovr_s),
        .ovr_r_i   (ovr_r),
        .write_i   (req_write),
        .priv_i    (req_priv),
        .perm_ok_o (perm_ok)
    );

    acc_guard_verdict u_verdict (
        .mode_i    (cur_mode),
        .perm_ok_i (perm_ok),
        .verdict_o (verdict)
    );

    // Transitions: "take" loads the verdict, "idle" returns to ST_IDLE.
    always_comb begin
        state_d = req_valid ? verdict : ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        rsp_valid      = 1'b0;
        rsp_allow      = 1'b0;
        rsp_dom_fault  = 1'b0;
        rsp_perm_fault = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_GRANT: begin
                rsp_valid = 1'b1;
                rsp_allow = 1'b1;
            end
            ST_DOM_FLT: begin
                rsp_valid     = 1'b1;
                rsp_dom_fault = 1'b1;
            end
            ST_PERM_FLT: begin
                rsp_valid      = 1'b1;
                rsp_perm_fault = 1'b1;
            end
            default: ;
        endcase
    end

    // Field picked straight from the port, used only for the checks below.
    logic [MODE_W-1:0] chk_mode;
    assign chk_mode = dacr[{req_domain, 1'b0} +: MODE_W];

    // R2 R3 R10
    dom_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !chk_mode[0]) |=> (rsp_dom_fault && !rsp_allow && !rsp_perm_fault));

    // R4
    owner_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && chk_mode == 2'b11) |=> (rsp_allow && !rsp_perm_fault));

    // R7
    ap_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && chk_mode == 2'b01 && req_ap == 2'b11) |=> rsp_allow);

    // R11
    lat_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R11
    lat_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R10
    one_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($countones({rsp_allow, rsp_dom_fault, rsp_perm_fault}) == 1));

    // R13
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !(rsp_allow || rsp_dom_fault || rsp_perm_fault));

endmodule

// File: tb/acc_guard_tb_top.sv
module acc_guard_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [3:0]  req_domain = '0;
    logic [1:0]  req_ap = '0;
    logic        req_write = 1'b0;
    logic        req_priv = 1'b0;
    logic [31:0] dacr = '0;
    logic        ovr_s = 1'b0;
    logic        ovr_r = 1'b0;
    logic        rsp_valid, rsp_allow, rsp_dom_fault, rsp_perm_fault;

    int n_tests = 0;
    int n_fail  = 0;

    logic [3:0] exp_q[$];   // {valid, allow, dom, perm}
    string      tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    acc_guard dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_domain(req_domain),
        .req_ap(req_ap), .req_write(req_write), .req_priv(req_priv), .dacr(dacr),
        .ovr_s(ovr_s), .ovr_r(ovr_r), .rsp_valid(rsp_valid), .rsp_allow(rsp_allow),
        .rsp_dom_fault(rsp_dom_fault), .rsp_perm_fault(rsp_perm_fault)
    );

    // Behavioural expectation straight from the requirement text.
    function automatic logic [3:0] model(input logic v, input int mode, input int ap,
                                         input logic s, input logic r,
                                         input logic w, input logic p);
        bit ok;
        if (!v) return 4'b0000;
        if (mode == 0 || mode == 2) return 4'b1010;
        if (mode == 3) return 4'b1100;
        case (ap)
            1: ok = p;
            2: ok = p || !w;
            3: ok = 1;
            default: begin
                if (s && !r)      ok = p && !w;
                else if (!s && r) ok = !w;
                else              ok = 0;
            end
        endcase
        return ok ? 4'b1100 : 4'b1001;
    endfunction

    function automatic string tag_of(input logic v, input int mode, input int ap,
                                     input logic s, input logic r);
        if (!v) return "R13";
        if (mode == 0) return "R2/R10";
        if (mode == 2) return "R3/R10";
        if (mode == 3) return "R4";
        if (ap == 1) return "R5";
        if (ap == 2) return "R6";
        if (ap == 3) return "R7";
        if (s && r) return "R9";
        return "R8";
    endfunction

    task automatic check_now();
        logic [3:0] exp;
        logic [3:0] act;
        string t;
        exp = (exp_q.size() > 0) ? exp_q.pop_front() : 4'b0000;
        t   = (tag_q.size() > 0) ? tag_q.pop_front() : "R11";
        act = {rsp_valid, rsp_allow, rsp_dom_fault, rsp_perm_fault};
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s (R11 timing): actual=%b expected=%b", t, act, exp);
        end
    endtask

    // Called just after a falling edge: check the previous request, then drive the next.
    task automatic step(input logic v, input int dom, input int ap, input logic w,
                        input logic p, input logic [31:0] cw, input logic s,
                        input logic r, input string extra);
        int mode;
        check_now();
        req_valid = v; req_domain = 4'(dom); req_ap = 2'(ap); req_write = w;
        req_priv = p; dacr = cw; ovr_s = s; ovr_r = r;
        mode = int'(cw[dom*2 +: 2]);
        exp_q.push_back(model(v, mode, ap, s, r, w, p));
        tag_q.push_back({extra, tag_of(v, mode, ap, s, r)});
        @(negedge clk);
    endtask

    task automatic check_reset();
        n_tests++;
        if ({rsp_valid, rsp_allow, rsp_dom_fault, rsp_perm_fault} !== 4'b0000) begin
            n_fail++;
            $display("FAIL R12: actual=%b expected=0000",
                     {rsp_valid, rsp_allow, rsp_dom_fault, rsp_perm_fault});
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL R11 watchdog: actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_reset();                       // R12 reset state
        rst_n = 1'b1;
        exp_q.push_back(4'b0000); tag_q.push_back("R12");
        @(negedge clk);

        // Exhaustive sweep: R2..R10, idle gaps for R11/R13.
        for (int m = 0; m < 4; m++) begin
            for (int ap = 0; ap < 4; ap++) begin
                for (int sr = 0; sr < 4; sr++) begin
                    for (int wp = 0; wp < 4; wp++) begin
                        int d;
                        logic [31:0] cw;
                        d  = (m * 5 + ap * 3 + sr + wp) % 16;
                        cw = 32'hFFFF_FFFF ^ (32'(m ^ 3) << (d * 2));
                        step(1'b1, d, ap, wp[1], wp[0], cw, sr[1], sr[0], "");
                        if (wp == 3) step(1'b0, d, ap, 1'b0, 1'b0, cw, 1'b0, 1'b0, "R11 ");
                    end
                end
            end
        end

        // R1: only domain k is owner, all others block.
        for (int k = 0; k < 16; k++) begin
            logic [31:0] cw;
            cw = 32'(3) << (k * 2);
            step(1'b1, k, 0, 1'b1, 1'b0, cw, 1'b0, 1'b0, "R1 ");
            step(1'b1, (k + 1) % 16, 3, 1'b0, 1'b1, cw, 1'b0, 1'b0, "R1 ");
        end
        // R1: only domain k is client, all others owner; permission fault expected.
        for (int k = 0; k < 16; k++) begin
            logic [31:0] cw;
            cw = 32'hFFFF_FFFF ^ (32'(2) << (k * 2));
            step(1'b1, k, 1, 1'b0, 1'b0, cw, 1'b0, 1'b0, "R1 ");
        end

        // R12: reset asserted while a request is present clears the outputs at once.
        step(1'b1, 2, 3, 1'b0, 1'b1, 32'h5555_5555, 1'b0, 1'b0, "");
        rst_n = 1'b0;
        #1;
        check_reset();
        exp_q.delete(); tag_q.delete();
        @(negedge clk);
        check_reset();
        rst_n = 1'b1;
        req_valid = 1'b0;
        exp_q.push_back(4'b0000); tag_q.push_back("R12");
        @(negedge clk);
        step(1'b1, 7, 2, 1'b1, 1'b0, 32'h5555_5555, 1'b0, 1'b0, "");
        step(1'b0, 0, 0, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, "R11 ");
        check_now();

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule